// File: doc/BRIEF.md
# Column Counter with Digital Multiple-Sample Averaging

This block is the digital end of one column of a single-slope converter. A ramp is compared against the pixel level. While the ramp window is open and the comparator reports high, the block adds one count per clock. A conversion has two phases. The reset level is converted M times and the per-ramp counts are summed into one register. A strobe then flips every bit of that register. The signal level is converted M more times, and counting continues upward from the flipped value.

Flipping every bit turns a sum R into -R-1. After the signal ramps the register holds S-R-1. The output stage adds one and shifts arithmetically right by log2(M). The result is the signed average difference, and no separate subtractor is needed. A start strobe captures the resolution (10 or 12 bits) and the sample count, and clears the register. A one-cycle pulse marks a new result.

Top module: `cms_column_counter`

## Requirements
- R1: Within one window (`win_i` high), a count is added on each rising clock edge that samples `cmp_i` high, until the first edge that samples `cmp_i` low. The comparator going high again later in the same window adds nothing.
- R2: The count of one window never exceeds 1023 in 10-bit mode (`res12_i`=0) or 4095 in 12-bit mode (`res12_i`=1). A comparator stuck high gives exactly that full-scale count.
- R3: In the reset phase, the counts of M consecutive windows add into the register without clearing. After the M-th window closes, the block waits for the inversion strobe.
- R4: An `inv_i` pulse sampled while waiting, with `win_i` low, replaces the register with its one's complement. The signal phase of M windows then counts upward from that value.
- R5: The result is floor((S-R)/M), as a two's complement value in 15 bits, where R and S are the reset-phase and signal-phase sums. Equal sums give exactly 0.
- R6: `valid_o` is high for exactly one cycle. It rises on the edge that samples `win_i` low at the end of the M-th signal window. `result_o` holds its value until the next result.
- R7: M = 2^`samp_log2_i`, captured at `sof_i`. In 10-bit mode a value above 4 is clamped to 4 (M=16). In 12-bit mode a value above 2 is clamped to 2 (M=4).
- R8: An `inv_i` sampled while `win_i` is high is ignored, and `err_o` pulses high on the following cycle.
- R9: Windows are not counted before the first `sof_i`, after the last reset window and before inversion, or after a result.
- R10: After reset, `valid_o`, `err_o` and `result_o` are all 0.
- R11: `sof_i` clears the register and the ramp counter and restarts the reset phase, even in the middle of a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock shared by all columns |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Start-of-conversion strobe; clears and captures config |
| res12_i | input | 1 | 1 selects 12-bit, 0 selects 10-bit resolution |
| samp_log2_i | input | 3 | log2 of the sample count M, clamped per R7 |
| win_i | input | 1 | Ramp window active |
| cmp_i | input | 1 | Comparator output, high while counting |
| inv_i | input | 1 | Phase inversion strobe |
| result_o | output | 15 | Averaged signed difference |
| valid_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Inversion strobe arrived during a window |

## Verification
The hardest states to reach are the ones where the comparator holds a window long enough to saturate, and where control strobes land at awkward moments. Those moments are an inversion inside an open window, a window opened between the reset phase and the inversion, and a start strobe in the middle of a conversion. Directed runs create each of these. They use windows longer than full scale, an inversion pulse placed in a chosen cycle of a reset ramp, an extra ramp driven before the inversion, and a conversion abandoned after one ramp. Seeded random conversions with any raw configuration code cover the clamping and the averaging of negative differences.

// File: rtl/cms_pkg.sv
package cms_pkg;
    localparam int CNT_W     = 15;
    localparam int RC_W      = 12;
    localparam int LG_W      = 3;
    localparam int LO_BITS   = 10;
    localparam int HI_BITS   = 12;
    localparam int LO_LG_MAX = 4;
    localparam int HI_LG_MAX = 2;
    localparam int RAMP_W    = LO_LG_MAX + 1;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_RST  = 3'd1,
        PH_WAIT = 3'd2,
        PH_SIG  = 3'd3,
        PH_DONE = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e                   phase;
        logic signed [CNT_W-1:0]  acc;
        logic [RAMP_W-1:0]        ramps;
        logic [LG_W-1:0]          lg;
        logic                     res12;
        logic signed [CNT_W-1:0]  res;
        logic                     valid;
        logic                     err;
    } conv_t;

    function automatic logic [RC_W-1:0] full_scale(input logic res12);
        if (res12) full_scale = RC_W'((1 << HI_BITS) - 1);
        else       full_scale = RC_W'((1 << LO_BITS) - 1);
    endfunction
endpackage

// File: rtl/cms_cfg_legalize.sv
module cms_cfg_legalize
    import cms_pkg::*;
(
    input  logic            res12_i,
    input  logic [LG_W-1:0] lg_raw_i,
    output logic [LG_W-1:0] lg_o
);
    logic [LG_W-1:0] lg_max;

    always_comb begin
        lg_max = res12_i ? LG_W'(HI_LG_MAX) : LG_W'(LO_LG_MAX);
        lg_o   = (lg_raw_i > lg_max) ? lg_max : lg_raw_i;
    end
endmodule

// File: rtl/cms_ramp_gate.sv
module cms_ramp_gate
    import cms_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            arm_i,
    input  logic            win_i,
    input  logic            cmp_i,
    input  logic [RC_W-1:0] full_i,
    output logic            inc_o,
    output logic            ramp_end_o,
    output logic [RC_W-1:0] rcnt_o
);
    typedef struct packed {
        logic [RC_W-1:0] rc;
        logic            stop;
        logic            win;
    } gate_t;

    gate_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        inc_o      = arm_i && win_i && cmp_i && !cur_q.stop && (cur_q.rc != full_i);
        ramp_end_o = cur_q.win && !win_i;
        nxt_d.win  = win_i;
        if (clr_i || !win_i) begin
            nxt_d.rc   = '0;
            nxt_d.stop = 1'b0;
        end else begin
            if (inc_o)  nxt_d.rc   = cur_q.rc + 1'b1;
            if (!cmp_i) nxt_d.stop = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rcnt_o = cur_q.rc;
endmodule

// File: rtl/cms_avg_out.sv
module cms_avg_out
    import cms_pkg::*;
(
    input  logic signed [CNT_W-1:0] acc_i,
    input  logic [LG_W-1:0]         lg_i,
    output logic signed [CNT_W-1:0] avg_o
);
    logic signed [CNT_W-1:0] corr;

    always_comb begin
        corr  = acc_i + CNT_W'(1);
        avg_o = corr >>> lg_i;
    end
endmodule

// File: rtl/cms_column_counter.sv
module cms_column_counter
    import cms_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic             res12_i,
    input  logic [LG_W-1:0]  samp_log2_i,
    input  logic             win_i,
    input  logic             cmp_i,
    input  logic             inv_i,
    output logic [CNT_W-1:0] result_o,
    output logic             valid_o,
    output logic             err_o
);
    conv_t cur_q, nxt_d;

    logic [LG_W-1:0]         lg_legal;
    logic                    armed;
    logic                    inc;
    logic                    ramp_end;
    logic [RC_W-1:0]         full;
    logic [RC_W-1:0]         rcnt;
    logic signed [CNT_W-1:0] avg;
    logic [RAMP_W-1:0]       last_ramp;
    logic                    in_wait;

    cms_cfg_legalize u_leg (
        .res12_i  (res12_i),
        .lg_raw_i (samp_log2_i),
        .lg_o     (lg_legal)
    );

    assign armed     = (cur_q.phase == PH_RST || cur_q.phase == PH_SIG) && !sof_i;
    assign full      = full_scale(cur_q.res12);
    assign last_ramp = RAMP_W'((1 << cur_q.lg) - 1);
    assign in_wait   = (cur_q.phase == PH_WAIT);

    cms_ramp_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (sof_i),
        .arm_i      (armed),
        .win_i      (win_i),
        .cmp_i      (cmp_i),
        .full_i     (full),
        .inc_o      (inc),
        .ramp_end_o (ramp_end),
        .rcnt_o     (rcnt)
    );

    cms_avg_out u_avg (
        .acc_i (cur_q.acc),
        .lg_i  (cur_q.lg),
        .avg_o (avg)
    );

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        nxt_d.err   = inv_i && win_i;
        if (sof_i) begin
            nxt_d.phase = PH_RST;
            nxt_d.acc   = '0;
            nxt_d.ramps = '0;
            nxt_d.lg    = lg_legal;
            nxt_d.res12 = res12_i;
        end else begin
            unique case (cur_q.phase)
                PH_RST: begin
                    if (inc) nxt_d.acc = cur_q.acc + CNT_W'(1);
                    if (ramp_end) begin
                        if (cur_q.ramps == last_ramp) begin
                            nxt_d.phase = PH_WAIT;
                            nxt_d.ramps = '0;
                        end else begin
                            nxt_d.ramps = cur_q.ramps + 1'b1;
                        end
                    end
                end
                PH_WAIT: begin
                    if (inv_i && !win_i) begin
                        nxt_d.acc   = ~cur_q.acc;
                        nxt_d.phase = PH_SIG;
                    end
                end
                PH_SIG: begin
                    if (inc) nxt_d.acc = cur_q.acc + CNT_W'(1);
                    if (ramp_end) begin
                        if (cur_q.ramps == last_ramp) begin
                            nxt_d.phase = PH_DONE;
                            nxt_d.ramps = '0;
                            nxt_d.res   = avg;
                            nxt_d.valid = 1'b1;
                        end else begin
                            nxt_d.ramps = cur_q.ramps + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign result_o = cur_q.res;
    assign valid_o  = cur_q.valid;
    assign err_o    = cur_q.err;
endmodule

// File: rtl/cms_column_counter_chk.sv
module cms_column_counter_chk
    import cms_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sof_i,
    input logic                    win_i,
    input logic                    inv_i,
    input logic                    valid_o,
    input logic                    err_o,
    input logic                    in_wait,
    input logic signed [CNT_W-1:0] acc,
    input logic [RC_W-1:0]         rcnt,
    input logic [RC_W-1:0]         full,
    input logic [LG_W-1:0]         lg,
    input logic                    res12
);
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_valid_after_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !$past(win_i));

    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($past(inv_i) && $past(win_i)));

    p_ramp_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rcnt <= full);

    p_hold_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && !inv_i && !sof_i) |=> $stable(acc));

    p_invert_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && inv_i && !win_i && !sof_i) |=> (acc == ~$past(acc)));

    p_cfg_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lg <= LG_W'(LO_LG_MAX)) && (!res12 || lg <= LG_W'(HI_LG_MAX)));
endmodule

bind cms_column_counter cms_column_counter_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sof_i   (sof_i),
    .win_i   (win_i),
    .inv_i   (inv_i),
    .valid_o (valid_o),
    .err_o   (err_o),
    .in_wait (in_wait),
    .acc     (cur_q.acc),
    .rcnt    (rcnt),
    .full    (full),
    .lg      (cur_q.lg),
    .res12   (cur_q.res12)
);

// File: tb/test_cms_column_counter.sv
module test_cms_column_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_i = 1'b0;
    logic        res12_i = 1'b0;
    logic [2:0]  samp_log2_i = 3'd0;
    logic        win_i = 1'b0;
    logic        cmp_i = 1'b0;
    logic        inv_i = 1'b0;
    logic [14:0] result_o;
    logic        valid_o;
    logic        err_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int hr[16];
    int hs[16];
    int seed_dummy;

    always #2.5 clk = ~clk;

    cms_column_counter i_cms_column_counter (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .res12_i(res12_i),
        .samp_log2_i(samp_log2_i), .win_i(win_i), .cmp_i(cmp_i),
        .inv_i(inv_i), .result_o(result_o), .valid_o(valid_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int legal_lg(input bit r12, input int raw);
        int mx = r12 ? 2 : 4;
        return (raw > mx) ? mx : raw;
    endfunction

    function automatic int ramp_val(input bit r12, input int h, input int len);
        int fs = r12 ? 4095 : 1023;
        int v = (h < len) ? h : len;
        return (v > fs) ? fs : v;
    endfunction

    // One window of length len; comparator high for h edges, optional
    // re-rise after it fell, optional inversion pulse at cycle inv_at.
    task automatic ramp(input int h, input int len, input bit rebound, input int inv_at);
        for (int i = 0; i < len; i++) begin
            win_i = 1'b1;
            cmp_i = (i < h) || (rebound && i >= h + 2 && i < h + 5);
            inv_i = (i == inv_at);
            @(negedge clk);
            if (i == inv_at) begin
                inv_i = 1'b0;
                chk(err_o === 1'b1, "R8 err pulse", int'(err_o), 1);
            end
        end
        win_i = 1'b0;
        cmp_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_sof(input bit r12, input int raw);
        res12_i = r12;
        samp_log2_i = 3'(raw);
        sof_i = 1'b1;
        @(negedge clk);
        sof_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_conv(input bit r12, input int raw, input bit extra,
                            input int inv_at, input bit rebound, input string tag);
        int lg = legal_lg(r12, raw);
        int m = 1 << lg;
        int sr = 0;
        int ss = 0;
        int diff;
        int exp;
        pulse_sof(r12, raw);
        for (int k = 0; k < m; k++) begin
            int len = hr[k] + 8;
            if (hr[k] > 5000) len = 4300;
            sr += ramp_val(r12, hr[k], len);
            ramp(hr[k], len, rebound, (k == 0) ? inv_at : -1);
            @(negedge clk);
        end
        if (extra) begin
            ramp(30, 40, 1'b0, -1);
            @(negedge clk);
        end
        inv_i = 1'b1;
        @(negedge clk);
        inv_i = 1'b0;
        @(negedge clk);
        for (int k = 0; k < m; k++) begin
            int len = hs[k] + 8;
            if (hs[k] > 5000) len = 4300;
            ss += ramp_val(r12, hs[k], len);
            ramp(hs[k], len, rebound, -1);
            if (k < m - 1) begin
                chk(valid_o === 1'b0, {tag, " R6 no early valid"}, int'(valid_o), 0);
                @(negedge clk);
            end
        end
        diff = ss - sr;
        exp = diff >>> lg;
        chk(valid_o === 1'b1, {tag, " R6 valid"}, int'(valid_o), 1);
        chk($signed(result_o) == exp, {tag, " R5 result"}, int'($signed(result_o)), exp);
        @(negedge clk);
        chk(valid_o === 1'b0, {tag, " R6 one cycle"}, int'(valid_o), 0);
        chk($signed(result_o) == exp, {tag, " R6 held"}, int'($signed(result_o)), exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        seed_dummy = $urandom(32'h5eed_c0de);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(valid_o === 1'b0, "R10 valid", int'(valid_o), 0);
        chk(err_o === 1'b0, "R10 err", int'(err_o), 0);
        chk(result_o === 15'd0, "R10 result", int'(result_o), 0);

        // R9 window before any start is ignored
        ramp(50, 60, 1'b0, -1);
        chk(valid_o === 1'b0, "R9 idle window", int'(valid_o), 0);

        // R5 equal sums give zero, M=4
        for (int k = 0; k < 16; k++) begin hr[k] = 100 + k; hs[k] = 100 + k; end
        run_conv(1'b0, 2, 1'b0, -1, 1'b0, "R5 zero");

        // R1 re-rise inside window ignored, M=2
        for (int k = 0; k < 16; k++) begin hr[k] = 20; hs[k] = 45; end
        run_conv(1'b0, 1, 1'b0, -1, 1'b1, "R1 rebound");

        // R5 negative floor: S-R=-3, M=2 -> -2
        hr[0] = 10; hr[1] = 12; hs[0] = 9; hs[1] = 10;
        run_conv(1'b0, 1, 1'b0, -1, 1'b0, "R5 floor");

        // R2 saturation 10-bit and 12-bit, M=1
        hr[0] = 6000; hs[0] = 5;
        run_conv(1'b0, 0, 1'b0, -1, 1'b0, "R2 sat10");
        hr[0] = 10; hs[0] = 6000;
        run_conv(1'b1, 0, 1'b0, -1, 1'b0, "R2 sat12");

        // R8 inversion inside reset window ignored; R3/R4 still correct
        for (int k = 0; k < 16; k++) begin hr[k] = 30; hs[k] = 70; end
        run_conv(1'b0, 3, 1'b0, 10, 1'b0, "R8 inv in window");

        // R9 window between reset phase and inversion ignored
        run_conv(1'b0, 2, 1'b1, -1, 1'b0, "R9 wait window");

        // R7 clamp: 12-bit raw 4 -> M=4; 10-bit raw 7 -> M=16
        for (int k = 0; k < 16; k++) begin hr[k] = 5 * k; hs[k] = 7 * k + 3; end
        run_conv(1'b1, 4, 1'b0, -1, 1'b0, "R7 clamp12");
        run_conv(1'b0, 7, 1'b0, -1, 1'b0, "R7 clamp10");

        // R11 abandon a conversion mid-way, restart
        pulse_sof(1'b0, 2);
        ramp(200, 210, 1'b0, -1);
        for (int k = 0; k < 16; k++) begin hr[k] = 15; hs[k] = 40; end
        run_conv(1'b0, 2, 1'b0, -1, 1'b0, "R11 restart");

        // R3 R4 R5 R7 seeded random conversions
        for (int n = 0; n < 12; n++) begin
            bit r12 = 1'($urandom_range(0, 1));
            int raw = $urandom_range(0, 7);
            for (int k = 0; k < 16; k++) begin
                hr[k] = $urandom_range(0, 200);
                hs[k] = $urandom_range(0, 200);
            end
            run_conv(r12, raw, 1'b0, -1, 1'($urandom_range(0, 1)), "R3 R4 random");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule